// File: doc/BRIEF.md
# Reconfiguration ID List Sequencer

This block holds an ordered list of reconfiguration profile IDs and hands them, one at a time, to a downstream apply engine. Software fills twenty 32-bit list words through a small memory-mapped port. Each word carries two ID slots, and each slot has a flag that chooses between the profile's own settings and its neutral-state settings. The port also returns the words and a status register.

A single-cycle start launches a walk. The walk visits the slots in list order and presents each nonzero ID on a valid/ack handshake. It stops at the first zero ID or after the last slot. While the walk runs, the block shows busy, refuses list writes and ignores further starts. It raises a one-cycle done pulse when the walk ends and keeps a count of the IDs it issued.

Top module: `recfg_id_seq`

## Requirements
- R1: In each list word the first slot's ID sits in bits 14:0 with its flag in bit 15, and the second slot's ID sits in bits 30:16 with its flag in bit 31. `req_active` carries the issued slot's flag: 1 selects profile settings and 0 selects neutral-state settings.
- R2: List word k (k = 0..19) is read and written at `cfg_addr` = k. All words reset to zero. A read is permitted at any time, including during a walk, and returns the stored word.
- R3: Words are walked in ascending index order, and inside a word the slot in bits 14:0 is issued before the slot in bits 30:16.
- R4: A zero ID ends the walk and is never issued, and no later slot is issued whatever it holds. If the first slot is zero, busy is high for exactly one cycle and no request appears.
- R5: An issued ID and its flag stay on `req_id`/`req_active` with `req_valid` high until `req_ack` is sampled high. Only then does the walk move to the next slot.
- R6: A write to any list word while busy is high leaves that word unchanged.
- R7: A start sampled while busy is high, including in the cycle the walk terminates, has no effect on the walk, the count or the busy output.
- R8: Busy rises in the cycle after an accepted start and falls in the cycle after termination. Ready is always the complement of busy. `req_valid` is low whenever busy is low.
- R9: Done is high for exactly one cycle, namely the first cycle in which busy is low after a walk.
- R10: When all 40 slots are nonzero, the walk issues 40 IDs and ends normally after the acknowledgement of the slot in bits 30:16 of word 19.
- R11: Reading `cfg_addr` = 20 returns the number of IDs issued by the current or most recent walk in its low bits, with the upper bits zero. The count is cleared by an accepted start and is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the list port |
| cfg_addr | input | 5 | Word address: 0..19 list, 20 status |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| start | input | 1 | Launches a walk when idle |
| req_valid | output | 1 | An ID is presented |
| req_id | output | 15 | Presented ID |
| req_active | output | 1 | 1 = profile settings, 0 = neutral-state settings |
| req_ack | input | 1 | Downstream engine accepts the presented ID |
| busy | output | 1 | Walk in progress |
| ready | output | 1 | Complement of busy |
| done | output | 1 | One-cycle termination pulse |

## Verification
Two pairs of functions can fall in the same cycle. First, a list write can coincide with an accepted start. Second, a start can coincide with the final acknowledgement that ends a walk. The bench drives a word-0 write together with start and expects the new word to drive the walk, because the write lands while the block is still idle. It also asserts start on every acknowledgement of some walks, including the terminating one, and expects the issued sequence, the count and the single-cycle busy drop to match the reference list exactly.

// File: rtl/recfg_pkg.sv
package recfg_pkg;
    localparam int ID_W   = 15;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    typedef struct packed {
        logic            act;
        logic [ID_W-1:0] id;
    } slot_t;
endpackage

// File: rtl/recfg_cfg_bank.sv
module recfg_cfg_bank #(
    parameter int NUM_WORDS = 20,
    parameter int ADDR_W    = 5
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       wr_en,
    input  logic                                       lock,
    input  logic [ADDR_W-1:0]                          addr,
    input  logic [recfg_pkg::WORD_W-1:0]               wdata,
    output logic [NUM_WORDS-1:0][recfg_pkg::WORD_W-1:0] words_o
);
    typedef struct packed {
        logic [NUM_WORDS-1:0][recfg_pkg::WORD_W-1:0] words;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (wr_en && !lock && addr == ADDR_W'(i)) begin
                st_d.words[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign words_o = st_q.words;
endmodule

// File: rtl/recfg_walker.sv
module recfg_walker #(
    parameter int NUM_SLOTS  = 40,
    parameter int SLOT_IDX_W = 6,
    parameter int CNT_W      = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  recfg_pkg::slot_t      cur_slot,
    input  logic                  req_ack,
    output logic [SLOT_IDX_W-1:0] slot_idx,
    output logic                  req_valid,
    output logic                  busy,
    output logic                  done,
    output logic [CNT_W-1:0]      issued_cnt
);
    localparam logic [SLOT_IDX_W-1:0] LAST_SLOT = SLOT_IDX_W'(NUM_SLOTS - 1);

    typedef struct packed {
        logic                  busy;
        logic                  done;
        logic [SLOT_IDX_W-1:0] slot;
        logic [CNT_W-1:0]      cnt;
    } walk_st_t;

    walk_st_t st_d, st_q;
    logic     slot_zero;

    assign slot_zero = (cur_slot.id == '0);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        req_valid = st_q.busy && !slot_zero;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.slot = '0;
                st_d.cnt  = '0;
            end
        end else if (slot_zero) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end else if (req_ack) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.slot == LAST_SLOT) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.slot = st_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_idx   = st_q.slot;
    assign busy       = st_q.busy;
    assign done       = st_q.done;
    assign issued_cnt = st_q.cnt;
endmodule

// File: rtl/recfg_rd_mux.sv
module recfg_rd_mux #(
    parameter int NUM_WORDS = 20,
    parameter int ADDR_W    = 5,
    parameter int CNT_W     = 6
) (
    input  logic [ADDR_W-1:0]                           addr,
    input  logic [NUM_WORDS-1:0][recfg_pkg::WORD_W-1:0] words,
    input  logic [CNT_W-1:0]                            cnt,
    output logic [recfg_pkg::WORD_W-1:0]                rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata = words[i];
            end
        end
        if (addr == ADDR_W'(NUM_WORDS)) begin
            rdata = {{(recfg_pkg::WORD_W - CNT_W){1'b0}}, cnt};
        end
    end
endmodule

// File: rtl/recfg_id_seq.sv
module recfg_id_seq #(
    parameter int NUM_WORDS = 20,
    parameter int ADDR_W    = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        start,
    output logic        req_valid,
    output logic [14:0] req_id,
    output logic        req_active,
    input  logic        req_ack,
    output logic        busy,
    output logic        ready,
    output logic        done
);
    import recfg_pkg::*;

    localparam int NUM_SLOTS  = 2 * NUM_WORDS;
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);
    localparam int CNT_W      = $clog2(NUM_SLOTS + 1);

    logic [NUM_WORDS-1:0][WORD_W-1:0] words_q;
    logic [SLOT_IDX_W-1:0]            slot_idx;
    logic [WORD_W-1:0]                cur_word;
    slot_t                            cur_slot;
    logic [CNT_W-1:0]                 issued_cnt;

    recfg_cfg_bank #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .lock(busy),
        .addr(cfg_addr), .wdata(cfg_wdata), .words_o(words_q)
    );

    assign cur_word = words_q[slot_idx[SLOT_IDX_W-1:1]];
    assign cur_slot = slot_idx[0] ? cur_word[WORD_W-1:HALF_W] : cur_word[HALF_W-1:0];

    recfg_walker #(.NUM_SLOTS(NUM_SLOTS), .SLOT_IDX_W(SLOT_IDX_W), .CNT_W(CNT_W)) walk_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cur_slot(cur_slot),
        .req_ack(req_ack), .slot_idx(slot_idx), .req_valid(req_valid),
        .busy(busy), .done(done), .issued_cnt(issued_cnt)
    );

    recfg_rd_mux #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) rd_i (
        .addr(cfg_addr), .words(words_q), .cnt(issued_cnt), .rdata(cfg_rdata)
    );

    assign req_id     = cur_slot.id;
    assign req_active = cur_slot.act;
    assign ready      = ~busy;
endmodule

// File: rtl/recfg_id_seq_chk.sv
module recfg_id_seq_chk #(
    parameter int NUM_WORDS = 20
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic                       req_valid,
    input logic [14:0]                req_id,
    input logic                       req_active,
    input logic                       req_ack,
    input logic                       busy,
    input logic                       done,
    input logic                       cfg_we,
    input logic [NUM_WORDS-1:0][31:0] words
);
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_id) && $stable(req_active)));

    assert_id_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_id != 15'd0));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);

    assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_wr_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we) |=> $stable(words));
endmodule

bind recfg_id_seq recfg_id_seq_chk #(.NUM_WORDS(NUM_WORDS)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
    .req_id(req_id), .req_active(req_active), .req_ack(req_ack),
    .busy(busy), .done(done), .cfg_we(cfg_we), .words(words_q)
);

// File: tb/recfg_id_seq_tb.sv
`timescale 1ns/1ps
module recfg_id_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        start = 1'b0;
    logic        req_valid;
    logic [14:0] req_id;
    logic        req_active;
    logic        req_ack = 1'b0;
    logic        busy, ready, done;

    int total = 0;
    int bad = 0;
    logic [31:0] model [20];
    logic [14:0] exp_id [40];
    logic        exp_act [40];
    int          exp_n;

    always #2.5 clk = ~clk;

    recfg_id_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .start(start),
        .req_valid(req_valid), .req_id(req_id), .req_active(req_active),
        .req_ack(req_ack), .busy(busy), .ready(ready), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic void compute_exp();
        exp_n = 0;
        for (int s = 0; s < 40; s++) begin
            logic [15:0] h;
            h = s[0] ? model[s/2][31:16] : model[s/2][15:0];
            if (h[14:0] == 15'd0) break;
            exp_id[exp_n]  = h[14:0];
            exp_act[exp_n] = h[15];
            exp_n++;
        end
    endfunction

    function automatic logic [15:0] rnd_slot(input int zero_odds);
        logic [15:0] h;
        h[15]   = 1'($urandom % 2);
        h[14:0] = 15'(($urandom % 32767) + 1);
        if (zero_odds > 0 && ($urandom % zero_odds) == 0) h[14:0] = '0;
        return h;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model[a] = d;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        cfg_addr = 5'(a);
        #0.5;
        d = cfg_rdata;
    endtask

    task automatic do_walk(input int maxdly, input bit inj_start, input bit inj_wr,
                           input bit wr_with_start, input logic [31:0] w0);
        int got = 0;
        int cyc = 0;
        bit fin = 0;
        logic [31:0] r;
        logic [31:0] keep19;
        if (wr_with_start) model[0] = w0;
        keep19 = model[19];
        compute_exp();
        @(negedge clk);
        start = 1'b1;
        if (wr_with_start) begin cfg_we = 1'b1; cfg_addr = 5'd0; cfg_wdata = w0; end
        @(negedge clk);
        start = 1'b0; cfg_we = 1'b0;
        chk(busy && !ready, "R8 busy after start", {30'd0, busy, ready}, 32'd2);
        while (!fin && cyc < 1000) begin
            if (done) begin
                fin = 1;
                chk(!busy && ready, "R9 done with busy low", {31'd0, busy}, 32'd0);
            end else if (req_valid) begin
                int dly;
                if (got < exp_n)
                    chk(req_id == exp_id[got] && req_active == exp_act[got], "R1 R3 issued slot",
                        {16'd0, req_active, req_id}, {16'd0, exp_act[got], exp_id[got]});
                else
                    chk(0, "R4 extra request", {17'd0, req_id}, 32'd0);
                dly = int'($urandom % (maxdly + 1));
                for (int d = 0; d < dly; d++) begin
                    if (inj_wr && d == 0) begin
                        cfg_we = 1'b1; cfg_addr = 5'd19; cfg_wdata = ~keep19;
                    end
                    @(negedge clk);
                    cfg_we = 1'b0;
                    cyc++;
                    if (got < exp_n)
                        chk(req_valid && req_id == exp_id[got], "R5 hold until ack",
                            {16'd0, req_valid, req_id}, {16'd0, 1'b1, exp_id[got]});
                end
                req_ack = 1'b1;
                if (inj_start) start = 1'b1;
                if (inj_wr) begin cfg_we = 1'b1; cfg_addr = 5'd19; cfg_wdata = ~keep19; end
                @(negedge clk);
                req_ack = 1'b0; start = 1'b0; cfg_we = 1'b0;
                got++; cyc++;
            end else begin
                @(negedge clk);
                cyc++;
            end
        end
        chk(fin, "R9 done seen", {31'd0, fin}, 32'd1);
        chk(got == exp_n, "R4 R10 issued count", 32'(got), 32'(exp_n));
        @(negedge clk);
        chk(!done && !busy, "R9 R7 single pulse and idle", {30'd0, done, busy}, 32'd0);
        rd(20, r);
        chk(r == 32'(exp_n), "R11 status count", r, 32'(exp_n));
        if (inj_wr) begin
            rd(19, r);
            chk(r == keep19, "R6 locked write", r, keep19);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd7531));
        for (int i = 0; i < 20; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && ready && !done && !req_valid, "R8 reset state",
            {28'd0, busy, ready, done, req_valid}, 32'h4);
        for (int i = 0; i < 20; i++) begin
            rd(i, r);
            chk(r == 32'd0, "R2 reset word", r, 32'd0);
        end
        rd(20, r);
        chk(r == 32'd0, "R11 reset count", r, 32'd0);

        // R4: empty list, busy for one cycle, no request
        do_walk(0, 0, 0, 0, '0);

        // R2: write and read back
        for (int i = 0; i < 20; i++) wr(i, {rnd_slot(0), rnd_slot(0)} ^ 32'(i));
        for (int i = 0; i < 20; i++) begin
            rd(i, r);
            chk(r == model[i], "R2 readback", r, model[i]);
        end

        // R10: all 40 nonzero, starts injected on every ack including the last (R7)
        for (int i = 0; i < 20; i++) wr(i, {1'b1, 15'(2*i+2), 1'b0, 15'(2*i+1)});
        do_walk(2, 1, 0, 0, '0);

        // R4: zero in high slot of word 3, nonzero after; locked write (R6)
        wr(3, {16'h0000, 16'h8123});
        do_walk(1, 0, 1, 0, '0);

        // R7 R8: write coinciding with start lands first
        do_walk(0, 0, 0, 1, {16'h0000, 16'h0042});

        // random walks
        for (int t = 0; t < 12; t++) begin
            for (int i = 0; i < 20; i++) wr(i, {rnd_slot(30), rnd_slot(30)});
            do_walk(3, t[0], t[1], 0, '0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule